// File: doc/BRIEF.md
# Half-Step and M/N Fractional Clock Divider

This block turns a source clock into a slower output clock in two stages. The first stage is a pre-divider that can divide by half-integer ratios. It works in units of source half-cycles and changes its output on both the rising and the falling source edge. The second stage is an optional M/N fractional stage. It lets through m of every n pre-divided pulses, spread evenly by an accumulator.

The overall output rate is source × 2 / (pre + 1) × m / n. The pre-divider field uses the "2 × divisor − 1" encoding, and a field of 0 also means divide by one. The fractional stage reads its modulus in complemented form: the N input carries the bitwise inverse of (n − m), and the stage recovers n as (~N & mask) + M. A mode field of zero bypasses the fractional stage. Any nonzero mode value, including the dual-edge code 2, enables it.

New settings never cut a pulse short. The pre-divider takes a new ratio only when a period starts. The fractional stage takes new values only at a pulse boundary, or while it is bypassed or silent. Source selection happens outside this block, so the block sees one source clock.

Top module: `halfstep_mn_div`

## Requirements
- R1: With pre-divider field p ≥ 1, one output period lasts p + 1 source half-cycles. Over W source cycles the output shows 2·W/(p + 1) rising edges, within one edge.
- R2: A pre-divider field of 0 or 1 divides by one: the output follows the source clock, high while the source is high.
- R3: When p + 1 is odd, the output is high for (p + 2)/2 and low for p/2 source half-cycles of each period. It therefore changes on rising and on falling source edges in turn.
- R4: A mode field of 0 (two bits) bypasses the fractional stage. The M and N values then have no effect on the output.
- R5: A nonzero mode field enables the fractional stage. It passes m of every n pre-divided pulses, with m = M and n = (~N & mask) + M for a counter width mask.
- R6: With the stage enabled and N all ones (so m equals n), every pre-divided pulse passes.
- R7: With the stage enabled and M equal to 0, the output stays low.
- R8: A new pre-divider value takes effect only at the start of a period. The period in progress finishes with its old high and low lengths.
- R9: While reset is asserted the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source clock, both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| preDiv | input | PRE_W | Pre-divider field, ratio (preDiv + 1)/2, 0 = divide by one |
| mnMode | input | 2 | Fractional stage mode, 0 = bypass, nonzero = active |
| mVal | input | MN_W | Numerator m |
| nVal | input | MN_W | Complement of (n − m) |
| divClk | output | 1 | Divided output clock |

## Verification
The bench builds the block with PRE_W = 4 and MN_W = 6. The 4-bit pre field covers both even and odd ratios up to 8 source cycles, and the 6-bit counter width keeps each fractional window short enough to count it many times within one measurement. Each setting is judged by the number of rising edges over 360 source cycles. That window is a whole multiple of every tested period, so the expected counts are exact to within the starting phase. Separate timing checks measure the length of the high phase. They cover the half-integer duty, the divide-by-one bypass, and a pre-divider change made in the middle of a long period.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;
  // Decisions from the control for the next edge of each polarity
  typedef struct packed {
    logic riseHigh;   // output level to drive at the coming rising edge
    logic fallHigh;   // output level to drive at the coming falling edge
  } edgeStrobe_t;
endpackage

// File: rtl/hsdiv_ctrl.sv
module hsdiv_ctrl
  import hsdiv_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic             srcClk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] preDiv,
  output edgeStrobe_t      strobe
);
  localparam int PW = PRE_W + 1;

  // posIdx: half-cycle position of the half-cycle that began at the last rising edge
  logic [PW-1:0] posIdx, cfgP;
  logic [PW-1:0] reqP, hiLen, stepTwo, stepOne, nextIdx, fallIdx;

  always_comb begin
    reqP    = (preDiv == '0) ? PW'(2) : (PW'(preDiv) + PW'(1));
    hiLen   = (cfgP + PW'(1)) >> 1;
    stepTwo = posIdx + PW'(2);
    nextIdx = (stepTwo >= cfgP) ? (stepTwo - cfgP) : stepTwo;
    stepOne = posIdx + PW'(1);
    fallIdx = (stepOne >= cfgP) ? (stepOne - cfgP) : stepOne;
    strobe.riseHigh = (nextIdx < hiLen);
    strobe.fallHigh = (fallIdx < hiLen);
  end

  // Ratio is reloaded only when a period begins on a rising edge
  always_ff @(posedge srcClk or negedge rst_n) begin
    if (!rst_n) begin
      posIdx <= '0;
      cfgP   <= PW'(2);
    end else begin
      posIdx <= nextIdx;
      if (nextIdx == '0) cfgP <= reqP;
    end
  end
endmodule

// File: rtl/hsdiv_edge_dp.sv
module hsdiv_edge_dp
  import hsdiv_pkg::*;
(
  input  logic        srcClk,
  input  logic        rst_n,
  input  edgeStrobe_t strobe,
  output logic        preClk
);
  logic posT, negT;

  // Each flop toggles so that the XOR takes the requested level
  always_ff @(posedge srcClk or negedge rst_n) begin
    if (!rst_n) posT <= 1'b0;
    else        posT <= strobe.riseHigh ^ negT;
  end

  always_ff @(negedge srcClk or negedge rst_n) begin
    if (!rst_n) negT <= 1'b0;
    else        negT <= strobe.fallHigh ^ posT;
  end

  assign preClk = posT ^ negT;
endmodule

// File: rtl/hsdiv_mn_stage.sv
module hsdiv_mn_stage #(
  parameter int MN_W = 8
) (
  input  logic            preClk,
  input  logic            rst_n,
  input  logic [1:0]      mnMode,
  input  logic [MN_W-1:0] mVal,
  input  logic [MN_W-1:0] nVal,
  output logic            divClk
);
  localparam int AW = MN_W + 1;
  localparam int SW = MN_W + 2;

  logic            activeOn, hitQ;
  logic [MN_W-1:0] activeM, nInv;
  logic [AW-1:0]   activeN, reqN;
  logic [SW-1:0]   acc, sum, nWide;
  logic            reqOn, wrap, window, changed;

  always_comb begin
    nInv    = ~nVal;
    reqN    = {1'b0, nInv} + {1'b0, mVal};
    reqOn   = (mnMode != 2'd0);
    nWide   = {1'b0, activeN};
    sum     = acc + {{(SW-MN_W){1'b0}}, activeM};
    wrap    = (activeM != '0) && (sum >= nWide);
    window  = !activeOn || (activeM == '0) || wrap;
    changed = (reqOn != activeOn) || (mVal != activeM) || (reqN != activeN);
  end

  // Steps once per pre-divided period, while the pre clock is low
  always_ff @(negedge preClk or negedge rst_n) begin
    if (!rst_n) begin
      activeOn <= 1'b0;
      activeM  <= '0;
      activeN  <= '0;
      acc      <= '0;
      hitQ     <= 1'b0;
    end else if (window && changed) begin
      activeOn <= reqOn;
      activeM  <= mVal;
      activeN  <= reqN;
      acc      <= '0;
      hitQ     <= 1'b0;
    end else begin
      hitQ <= wrap;
      acc  <= wrap ? (sum - nWide) : sum;
    end
  end

  assign divClk = activeOn ? (preClk & hitQ) : preClk;
endmodule

// File: rtl/halfstep_mn_div.sv
module halfstep_mn_div
  import hsdiv_pkg::*;
#(
  parameter int PRE_W = 5,
  parameter int MN_W  = 8
) (
  input  logic             srcClk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] preDiv,
  input  logic [1:0]       mnMode,
  input  logic [MN_W-1:0]  mVal,
  input  logic [MN_W-1:0]  nVal,
  output logic             divClk
);
  edgeStrobe_t strobe;
  logic        preClk;

  hsdiv_ctrl #(.PRE_W(PRE_W)) ctrl_i (
    .srcClk(srcClk), .rst_n(rst_n), .preDiv(preDiv), .strobe(strobe)
  );

  hsdiv_edge_dp dp_i (
    .srcClk(srcClk), .rst_n(rst_n), .strobe(strobe), .preClk(preClk)
  );

  hsdiv_mn_stage #(.MN_W(MN_W)) mn_i (
    .preClk(preClk), .rst_n(rst_n), .mnMode(mnMode),
    .mVal(mVal), .nVal(nVal), .divClk(divClk)
  );
endmodule

// File: rtl/hsdiv_chk.sv
module hsdiv_chk #(
  parameter int PRE_W = 5,
  parameter int MN_W  = 8
) (
  input logic                srcClk,
  input logic                rst_n,
  input logic [PRE_W:0]      posIdx,
  input logic [PRE_W:0]      cfgP,
  input logic                activeOn,
  input logic [MN_W-1:0]     activeM,
  input logic [MN_W:0]       activeN,
  input logic [MN_W+1:0]     acc,
  input logic                hitQ
);
  a_r1_idx_in_period: assert property (@(posedge srcClk) disable iff (!rst_n)
    posIdx < cfgP);

  a_r1_period_min_two: assert property (@(posedge srcClk) disable iff (!rst_n)
    cfgP >= (PRE_W+1)'(2));

  a_r8_reload_at_start: assert property (@(posedge srcClk) disable iff (!rst_n)
    (cfgP != $past(cfgP)) |-> (posIdx == '0));

  a_r5_acc_below_n: assert property (@(posedge srcClk) disable iff (!rst_n)
    (activeOn && (activeM != '0)) |-> (acc < {1'b0, activeN}));

  a_r7_silent_m_zero: assert property (@(posedge srcClk) disable iff (!rst_n)
    (activeOn && (activeM == '0)) |-> !hitQ);
endmodule

bind halfstep_mn_div hsdiv_chk #(.PRE_W(PRE_W), .MN_W(MN_W)) chk_i (
  .srcClk(srcClk), .rst_n(rst_n),
  .posIdx(ctrl_i.posIdx), .cfgP(ctrl_i.cfgP),
  .activeOn(mn_i.activeOn), .activeM(mn_i.activeM), .activeN(mn_i.activeN),
  .acc(mn_i.acc), .hitQ(mn_i.hitQ)
);

// File: tb/halfstep_mn_div_tb_top.sv
`timescale 1ns/1ps
module halfstep_mn_div_tb_top;
  localparam int PRE_W = 4;
  localparam int MN_W  = 6;
  localparam int WIN   = 360;
  localparam int NV    = 11;

  // {pre[3:0], mode[1:0], m[5:0], n[5:0]}
  localparam logic [17:0] VEC [NV] = '{
    {4'd0, 2'd0, 6'd1, 6'd1},
    {4'd1, 2'd0, 6'd1, 6'd1},
    {4'd2, 2'd0, 6'd1, 6'd1},
    {4'd3, 2'd0, 6'd1, 6'd1},
    {4'd4, 2'd0, 6'd1, 6'd1},
    {4'd0, 2'd2, 6'd1, 6'd3},
    {4'd2, 2'd2, 6'd2, 6'd5},
    {4'd5, 2'd1, 6'd3, 6'd4},
    {4'd0, 2'd0, 6'd1, 6'd3},
    {4'd1, 2'd2, 6'd3, 6'd3},
    {4'd7, 2'd3, 6'd1, 6'd2}
  };

  logic             srcClk = 1'b0;
  logic             rst_n  = 1'b0;
  logic [PRE_W-1:0] preDiv = '0;
  logic [1:0]       mnMode = '0;
  logic [MN_W-1:0]  mVal   = 6'd1;
  logic [MN_W-1:0]  nVal   = 6'h3f;
  logic             divClk;

  int checkCnt = 0;
  int failCnt  = 0;
  int edgeCnt  = 0;
  logic counting = 1'b0;
  bit done = 1'b0;

  halfstep_mn_div #(.PRE_W(PRE_W), .MN_W(MN_W)) dut_i (
    .srcClk(srcClk), .rst_n(rst_n), .preDiv(preDiv), .mnMode(mnMode),
    .mVal(mVal), .nVal(nVal), .divClk(divClk)
  );

  always #10 srcClk = ~srcClk;

  always @(posedge divClk) if (counting) edgeCnt++;

  function automatic int expEdges(int p, int md, int m, int n);
    int per;
    per = (p == 0) ? 2 : p + 1;
    if (md == 0) return (2 * WIN) / per;
    if (m == 0)  return 0;
    return (2 * WIN * m) / (per * n);
  endfunction

  function automatic string tagOf(int p, int md, int m, int n);
    if (md == 0) return (m != n) ? "R4" : ((p < 2) ? "R2" : "R1");
    return (m == n) ? "R6" : "R5";
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic apply(int p, int md, int m, int n);
    logic [MN_W-1:0] diff;
    @(negedge srcClk); #2;
    diff   = MN_W'(n - m);
    preDiv = PRE_W'(p);
    mnMode = 2'(md);
    mVal   = MN_W'(m);
    nVal   = ~diff;
    repeat (64) @(posedge srcClk);
  endtask

  task automatic countWindow(output int cnt);
    @(negedge srcClk); #2;
    edgeCnt  = 0;
    counting = 1'b1;
    repeat (WIN) @(negedge srcClk);
    #1;
    counting = 1'b0;
    cnt = edgeCnt;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int cnt, ex, hiCnt, bad;
    realtime t0;
    // R9: output held low in reset, across both clock phases
    repeat (3) begin
      @(posedge srcClk); #5;
      check(divClk == 1'b0, "R9", int'(divClk), 0);
    end
    @(negedge srcClk); #2;
    rst_n = 1'b1;

    // Table of settings: edges counted over one window
    for (int i = 0; i < NV; i++) begin
      int p, md, m, n;
      p  = int'(VEC[i][17:14]);
      md = int'(VEC[i][13:12]);
      m  = int'(VEC[i][11:6]);
      n  = int'(VEC[i][5:0]);
      apply(p, md, m, n);
      countWindow(cnt);
      ex = expEdges(p, md, m, n);
      check((cnt >= ex - 1) && (cnt <= ex + 1), tagOf(p, md, m, n), cnt, ex);
    end

    // R7: enabled stage with M = 0 stays silent
    apply(0, 2, 0, 3);
    countWindow(cnt);
    check(cnt == 0, "R7", cnt, 0);

    // R3: pre = 2 gives high for 2 of every 3 half-cycles
    apply(2, 0, 1, 1);
    @(posedge srcClk); #5;
    hiCnt = 0;
    repeat (30) begin
      if (divClk) hiCnt++;
      #10;
    end
    check(hiCnt == 20, "R3", hiCnt, 20);

    // R2: pre = 1 follows the source level
    apply(1, 0, 1, 1);
    @(posedge srcClk); #5;
    bad = 0;
    repeat (10) begin
      if (divClk !== srcClk) bad++;
      #10;
    end
    check(bad == 0, "R2", bad, 0);

    // R8: change pre from 9 to 2 during a long high phase
    apply(9, 0, 1, 1);
    @(posedge divClk);
    t0 = $realtime;
    @(negedge srcClk); #2;
    preDiv = PRE_W'(2);
    @(negedge divClk);
    check(($realtime - t0) == 50.0, "R8", int'($realtime - t0), 50);
    @(posedge divClk);
    t0 = $realtime;
    @(negedge divClk);
    check(($realtime - t0) == 20.0, "R8", int'($realtime - t0), 20);

    finishRun();
  end
endmodule